// File: doc/BRIEF.md
# DMA FIFO Diagnostic Access Unit

This block is the test and diagnostic control path around a word-wide DMA FIFO. It holds the DMA address pointer, the 24-bit byte counter, a byte-lane steering field for single-byte test access to the FIFO, a master set/reset control that drives the internal DMA write direction flag, and the master parity error interrupt gate. The normal data path is a 32-bit push/pop port. Diagnostic software uses a small register port to load and read the pointer and counter, to step them by one through self-clearing command bits, and to pick which byte of the FIFO entry is reached through the byte-wide test port.

When forced lane selection is on, the lane comes straight from the register field. When it is off, the lane follows the low two bits of the address pointer, so stepping the pointer walks through the bytes of an entry. The direction flag is never written directly. A direction command either asserts or deasserts it, depending on the master set/reset bit that is already in place.

Top module: `fdiag_unit`

## Requirements
- R1: With the force bit (control register, address 0, bit 2) at 1, the lane bits (address 0, bits 1:0) select lane n, and test access then reaches bits 8n+7:8n of the FIFO entry.
- R2: With the force bit at 0, the lane used for test access equals bits 1:0 of the address pointer.
- R3: Writing 1 to the address-step bit (command register, address 1, bit 0) adds 1 to the pointer (address 2) one cycle later, and the bit then reads 0.
- R4: Writing 1 to the count-step bit (address 1, bit 1) subtracts 1 from the byte counter (address 3, bits 23:0) one cycle later, and the bit then reads 0.
- R5: A count step while the counter is 0 leaves it at 0.
- R6: A command write that keeps the master bit (address 1, bit 2) unchanged and has the direction bit (address 1, bit 3) at 1 sets `dma_wr` to the master bit value. `dma_wr` reads back at address 1, bit 4, and a 1 means data flows from the SCSI side to the host side.
- R7: A command write that changes the master bit updates only the master bit, and `dma_wr` keeps its value in that cycle.
- R8: The parity enable (address 0, bit 3) resets to 0. While it is 0, `perr_in` never raises `perr_irq`. While it is 1, `perr_irq` goes high for one cycle, in the cycle after `perr_in`.
- R9: After reset all registers read 0, `dma_wr` and `perr_irq` are 0, and the FIFO is empty.
- R10: A test write changes only the selected byte of the entry at the FIFO write pointer. A test read returns that byte on bits 7:0 of `tst_rdata`, and bits 31:8 read 0.
- R11: Words leave the FIFO in push order. A push while full and a pop while empty are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 command, 2 pointer, 3 counter |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| tst_we | input | 1 | Test byte write strobe |
| tst_wdata | input | 8 | Test byte write data |
| tst_rdata | output | 32 | Selected byte of the entry, zero-extended |
| push | input | 1 | FIFO push |
| push_data | input | 32 | FIFO push word |
| pop | input | 1 | FIFO pop |
| pop_data | output | 32 | FIFO head word |
| fifo_full | output | 1 | FIFO full |
| fifo_empty | output | 1 | FIFO empty |
| perr_in | input | 1 | Master parity error event |
| dma_wr | output | 1 | DMA direction, 1 = SCSI to host |
| perr_irq | output | 1 | Master parity error interrupt request |

## Verification
The assertions assume that a register load of the pointer or counter never arrives in the same cycle as a pending step of that register, and that a test write and a push never share a cycle. The bench drives every strobe from a task that owns the bus for a whole cycle and waits for each step to finish before its next register write, so these cases never occur. It also drives every command write with the master bit it last wrote, except where a test means to change that bit.

// File: rtl/fdiag_pkg.sv
// Package: shared register selects, field positions and sizes for the
// DMA FIFO diagnostic access unit. Assumes a 2-bit register address.
package fdiag_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_PTR  = 2'd2,
        SEL_CNT  = 2'd3
    } reg_sel_e;

    localparam int BYTE_W     = 8;
    // control register fields
    localparam int CTRL_FORCE = 2;
    localparam int CTRL_PEN   = 3;
    // command register fields
    localparam int CMD_ASTEP  = 0;
    localparam int CMD_CSTEP  = 1;
    localparam int CMD_MSET   = 2;
    localparam int CMD_DIR    = 3;
    localparam int CMD_DMAWR  = 4;
endpackage

// File: rtl/fdiag_lane_steer.sv
// Module: fdiag_lane_steer
// Picks the FIFO byte lane used for test access. In forced mode the lane
// comes from the register field; otherwise from the low pointer bits.
// Purely combinational; assumes LANES is a power of two.
module fdiag_lane_steer #(
    parameter int LANES = 4,
    localparam int LW   = $clog2(LANES)
) (
    input  logic             force_en,
    input  logic [LW-1:0]    forced_lane,
    input  logic [LW-1:0]    ptr_low,
    output logic [LW-1:0]    lane_idx,
    output logic [LANES-1:0] lane_oh
);
    // choose the lane source
    always_comb lane_idx = force_en ? forced_lane : ptr_low;

    // expand the index into one enable per lane
    for (genvar g = 0; g < LANES; g++) begin : g_oh
        assign lane_oh[g] = (lane_idx == LW'(g));
    end
endmodule

// File: rtl/fdiag_ptr_cnt.sv
// Module: fdiag_ptr_cnt
// Holds the DMA address pointer and the byte counter. Loads take priority
// over steps. The pointer wraps on increment; the counter saturates at 0.
// Assumes step requests are single-cycle pulses.
module fdiag_ptr_cnt #(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_ld,
    input  logic          cnt_ld,
    input  logic [AW-1:0] ld_data,
    input  logic          astep,
    input  logic          cstep,
    output logic [AW-1:0] ptr,
    output logic [CW-1:0] cnt
);
    // address pointer: load, else increment on step
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr <= '0;
        else if (ptr_ld) ptr <= ld_data;
        else if (astep)  ptr <= ptr + AW'(1);
    end

    // byte counter: load, else decrement on step without going below zero
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (cnt_ld)                cnt <= ld_data[CW-1:0];
        else if (cstep && cnt != '0)    cnt <= cnt - CW'(1);
    end

    // the pointer moves up by exactly one after a step
    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        astep && !ptr_ld |=> ptr == $past(ptr) + AW'(1));

    // a nonzero counter moves down by exactly one after a step
    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cstep && !cnt_ld && cnt != '0 |=> cnt == $past(cnt) - CW'(1));

    // the counter stays at zero on a step
    assert_cnt_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cstep && !cnt_ld && cnt == '0 |=> cnt == '0);
endmodule

// File: rtl/fdiag_fifo.sv
// Module: fdiag_fifo
// Word-wide DMA FIFO with a byte-lane test port acting on the entry at the
// write pointer. A push in the same cycle as a test write wins. Pushes when
// full and pops when empty are dropped. Storage resets to zero.
module fdiag_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    localparam int LANES = DW / 8,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic [DW-1:0]    pop_data,
    output logic             full,
    output logic             empty,
    input  logic             tst_we,
    input  logic [LANES-1:0] lane_oh,
    input  logic [7:0]       tst_wbyte,
    output logic [7:0]       tst_rbyte
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [PW:0]   count;
    logic          do_push, do_pop;
    logic [DW-1:0] slot_word;

    // accepted transfers
    always_comb begin
        do_push = push && !full;
        do_pop  = pop && !empty;
    end

    // occupancy flags
    always_comb begin
        full  = (count == (PW+1)'(DEPTH));
        empty = (count == '0);
    end

    // head word and the entry at the write pointer
    always_comb begin
        pop_data  = mem[rptr];
        slot_word = mem[wptr];
    end

    // select the test byte from the write-pointer entry
    always_comb begin
        tst_rbyte = '0;
        for (int l = 0; l < LANES; l++)
            if (lane_oh[l]) tst_rbyte = slot_word[l*8 +: 8];
    end

    // storage: full-word push, or byte-lane test write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (do_push) begin
            mem[wptr] <= push_data;
        end else if (tst_we) begin
            for (int l = 0; l < LANES; l++)
                if (lane_oh[l]) mem[wptr][l*8 +: 8] <= tst_wbyte;
        end
    end

    // pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == PW'(DEPTH-1)) ? '0 : wptr + PW'(1);
            if (do_pop)  rptr <= (rptr == PW'(DEPTH-1)) ? '0 : rptr + PW'(1);
            count <= count + (PW+1)'(do_push) - (PW+1)'(do_pop);
        end
    end

    // unselected bytes of the entry survive a test write
    for (genvar g = 0; g < LANES; g++) begin : g_keep
        assert_lane_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
            tst_we && !push && !lane_oh[g] |=> $stable(slot_word[g*8 +: 8]));
    end

    // occupancy never exceeds the depth
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (PW+1)'(DEPTH));

    // a push while full leaves the occupancy alone
    assert_full_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop |=> full);
endmodule

// File: rtl/fdiag_unit.sv
// Module: fdiag_unit (top)
// Register port, step command pulses, master set/reset direction control
// and parity interrupt gate around the DMA FIFO, pointer and counter.
// Assumes reg_we is a single-cycle strobe per write and that the bus
// width covers the pointer.
module fdiag_unit
    import fdiag_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 32,
    parameter int CW    = 24,
    parameter int DEPTH = 8,
    localparam int LANES = DW / 8,
    localparam int LW    = $clog2(LANES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          tst_we,
    input  logic [7:0]    tst_wdata,
    output logic [31:0]   tst_rdata,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic          fifo_full,
    output logic          fifo_empty,
    input  logic          perr_in,
    output logic          dma_wr,
    output logic          perr_irq
);
    logic [LW-1:0]    lane_fld;
    logic             force_en, par_en;
    logic             astep_q, cstep_q, mset_q, dir_q;
    logic             ctrl_wr, cmd_wr, ptr_wr, cnt_wr;
    logic [AW-1:0]    ptr;
    logic [CW-1:0]    cnt;
    logic [LW-1:0]    lane_idx;
    logic [LANES-1:0] lane_oh;
    logic [7:0]       tst_rbyte;

    // decode the register write strobe
    always_comb begin
        ctrl_wr = reg_we && reg_sel_e'(reg_addr) == SEL_CTRL;
        cmd_wr  = reg_we && reg_sel_e'(reg_addr) == SEL_CMD;
        ptr_wr  = reg_we && reg_sel_e'(reg_addr) == SEL_PTR;
        cnt_wr  = reg_we && reg_sel_e'(reg_addr) == SEL_CNT;
    end

    // control register: lane field, force bit, parity enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_fld <= '0;
            force_en <= 1'b0;
            par_en   <= 1'b0;
        end else if (ctrl_wr) begin
            lane_fld <= reg_wdata[LW-1:0];
            force_en <= reg_wdata[CTRL_FORCE];
            par_en   <= reg_wdata[CTRL_PEN];
        end
    end

    // step bits: set by a write, cleared once consumed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            astep_q <= 1'b0;
            cstep_q <= 1'b0;
        end else begin
            astep_q <= cmd_wr && reg_wdata[CMD_ASTEP];
            cstep_q <= cmd_wr && reg_wdata[CMD_CSTEP];
        end
    end

    // master bit first; a direction command acts only when it is unchanged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mset_q <= 1'b0;
            dir_q  <= 1'b0;
            dma_wr <= 1'b0;
        end else if (cmd_wr) begin
            dir_q <= reg_wdata[CMD_DIR];
            if (reg_wdata[CMD_MSET] != mset_q)
                mset_q <= reg_wdata[CMD_MSET];
            else if (reg_wdata[CMD_DIR])
                dma_wr <= mset_q;
        end
    end

    // parity interrupt: one-cycle request when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) perr_irq <= 1'b0;
        else        perr_irq <= par_en && perr_in;
    end

    fdiag_ptr_cnt #(.AW(AW), .CW(CW)) u_ptr_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .ptr_ld  (ptr_wr),
        .cnt_ld  (cnt_wr),
        .ld_data (reg_wdata[AW-1:0]),
        .astep   (astep_q),
        .cstep   (cstep_q),
        .ptr     (ptr),
        .cnt     (cnt)
    );

    fdiag_lane_steer #(.LANES(LANES)) u_steer (
        .force_en    (force_en),
        .forced_lane (lane_fld),
        .ptr_low     (ptr[LW-1:0]),
        .lane_idx    (lane_idx),
        .lane_oh     (lane_oh)
    );

    fdiag_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .pop_data  (pop_data),
        .full      (fifo_full),
        .empty     (fifo_empty),
        .tst_we    (tst_we),
        .lane_oh   (lane_oh),
        .tst_wbyte (tst_wdata),
        .tst_rbyte (tst_rbyte)
    );

    // zero-extend the test byte
    always_comb tst_rdata = {24'd0, tst_rbyte};

    // register readback mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel_e'(reg_addr))
            SEL_CTRL: begin
                reg_rdata[LW-1:0]       = lane_fld;
                reg_rdata[CTRL_FORCE]   = force_en;
                reg_rdata[CTRL_PEN]     = par_en;
            end
            SEL_CMD: begin
                reg_rdata[CMD_ASTEP]    = astep_q;
                reg_rdata[CMD_CSTEP]    = cstep_q;
                reg_rdata[CMD_MSET]     = mset_q;
                reg_rdata[CMD_DIR]      = dir_q;
                reg_rdata[CMD_DMAWR]    = dma_wr;
            end
            SEL_PTR:  reg_rdata[AW-1:0] = ptr;
            SEL_CNT:  reg_rdata[CW-1:0] = cnt;
        endcase
    end

    // the lane follows the pointer when not forced
    assert_lane_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !force_en |-> lane_oh[ptr[LW-1:0]]);

    // a step bit is gone one cycle after it acted, unless rewritten
    assert_step_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        astep_q && !cmd_wr |=> !astep_q);

    // a direction command copies the held master bit
    assert_dir_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && reg_wdata[CMD_DIR] && reg_wdata[CMD_MSET] == mset_q
        |=> dma_wr == $past(mset_q));

    // a master-bit change freezes the direction flag
    assert_mset_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && reg_wdata[CMD_MSET] != mset_q |=> $stable(dma_wr));

    // no interrupt while parity checking is off
    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !par_en |=> !perr_irq);
endmodule

// File: tb/fdiag_unit_tb.sv
module fdiag_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tst_we = 1'b0;
    logic [7:0]  tst_wdata = '0;
    logic [31:0] tst_rdata;
    logic        push = 1'b0;
    logic [31:0] push_data = '0;
    logic        pop = 1'b0;
    logic [31:0] pop_data;
    logic        fifo_full, fifo_empty;
    logic        perr_in = 1'b0;
    logic        dma_wr, perr_irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [31:0] exp_q[$];

    always #4 clk = ~clk;

    fdiag_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tst_we(tst_we),
        .tst_wdata(tst_wdata), .tst_rdata(tst_rdata), .push(push),
        .push_data(push_data), .pop(pop), .pop_data(pop_data),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .perr_in(perr_in),
        .dma_wr(dma_wr), .perr_irq(perr_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic tw(input logic [7:0] b);
        @(negedge clk);
        tst_we = 1'b1; tst_wdata = b;
        @(negedge clk);
        tst_we = 1'b0;
    endtask

    // driver: push a word, queue it as expected when accepted
    task automatic drive_push(input logic [31:0] d);
        @(negedge clk);
        push = 1'b1; push_data = d;
        if (!fifo_full) exp_q.push_back(d);
        @(negedge clk);
        push = 1'b0;
    endtask

    task automatic drive_pop();
        @(negedge clk);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    // monitor: compare each accepted pop with the scoreboard front
    always @(negedge clk) begin
        #2;
        if (rst_n && pop && !fifo_empty) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R11 actual=%h expected=<none>", pop_data);
            end else begin
                chk("R11 pop order", pop_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        rd(2'd0, v); chk("R9 ctrl", v, 0);
        rd(2'd1, v); chk("R9 cmd", v, 0);
        rd(2'd2, v); chk("R9 ptr", v, 0);
        rd(2'd3, v); chk("R9 cnt", v, 0);
        chk("R9 dma_wr", {31'd0, dma_wr}, 0);
        chk("R9 irq", {31'd0, perr_irq}, 0);
        chk("R9 empty", {31'd0, fifo_empty}, 1);

        // R1 forced lanes: write a distinct byte to each
        for (int l = 0; l < 4; l++) begin
            wr(2'd0, 32'h4 | l);
            tw(8'h11 * (l + 1));
        end
        for (int l = 0; l < 4; l++) begin
            wr(2'd0, 32'h4 | l);
            #1 chk("R1 lane read", tst_rdata, 32'h11 * (l + 1));
        end
        // R10 overwrite lane 2 only
        wr(2'd0, 32'h6);
        tw(8'hC3);
        #1 chk("R10 lane2 new", tst_rdata, 32'hC3);
        wr(2'd0, 32'h4); #1 chk("R10 lane0 kept", tst_rdata, 32'h11);
        wr(2'd0, 32'h5); #1 chk("R10 lane1 kept", tst_rdata, 32'h22);
        wr(2'd0, 32'h7); #1 chk("R10 lane3 kept", tst_rdata, 32'h44);

        // R2 lane from pointer
        wr(2'd0, 32'h3);           // lane bits set, force off
        wr(2'd2, 32'h0000_1001);
        #1 chk("R2 ptr lane1", tst_rdata, 32'h22);

        // R3 address step
        wr(2'd1, 32'h1);
        @(negedge clk);
        rd(2'd2, v); chk("R3 ptr inc", v, 32'h0000_1002);
        rd(2'd1, v); chk("R3 bit clear", v & 32'h1, 0);
        #1 chk("R2 ptr lane2", tst_rdata, 32'hC3);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd1, 32'h1);
        @(negedge clk);
        rd(2'd2, v); chk("R3 ptr wrap", v, 0);

        // R4 count step, R5 saturation
        wr(2'd3, 32'h0000_0003);
        wr(2'd1, 32'h2);
        @(negedge clk);
        rd(2'd3, v); chk("R4 cnt dec", v, 2);
        rd(2'd1, v); chk("R4 bit clear", v & 32'h2, 0);
        wr(2'd3, 32'h0000_0001);
        wr(2'd1, 32'h2); @(negedge clk);
        rd(2'd3, v); chk("R5 to zero", v, 0);
        wr(2'd1, 32'h2); @(negedge clk);
        rd(2'd3, v); chk("R5 saturate", v, 0);

        // R6/R7 master set/reset direction control
        wr(2'd1, 32'h4);           // master bit 0->1 only
        #1 chk("R7 mset alone", {31'd0, dma_wr}, 0);
        wr(2'd1, 32'hC);           // direction with master 1
        #1 chk("R6 assert", {31'd0, dma_wr}, 1);
        rd(2'd1, v); chk("R6 readback", (v >> 4) & 1, 1);
        wr(2'd1, 32'h8);           // master 1->0 with direction: ignored
        #1 chk("R7 hold high", {31'd0, dma_wr}, 1);
        wr(2'd1, 32'h8);           // direction with master 0
        #1 chk("R6 deassert", {31'd0, dma_wr}, 0);
        wr(2'd1, 32'hC);           // master 0->1 with direction: ignored
        #1 chk("R7 hold low", {31'd0, dma_wr}, 0);

        // R8 parity gate
        @(negedge clk); perr_in = 1'b1;
        @(negedge clk); perr_in = 1'b0;
        #1 chk("R8 disabled", {31'd0, perr_irq}, 0);
        @(negedge clk); #1 chk("R8 disabled later", {31'd0, perr_irq}, 0);
        wr(2'd0, 32'h8);
        @(negedge clk); perr_in = 1'b1;
        @(negedge clk); perr_in = 1'b0;
        #1 chk("R8 irq pulse", {31'd0, perr_irq}, 1);
        @(negedge clk); #1 chk("R8 irq drop", {31'd0, perr_irq}, 0);

        // R11 FIFO order, fill past full, drain past empty
        for (int i = 0; i < 4; i++) drive_push(32'hA000_0000 + i);
        for (int i = 0; i < 4; i++) drive_pop();
        for (int i = 0; i < 9; i++) drive_push(32'h5000_0100 * (i + 1));
        #1 chk("R11 full", {31'd0, fifo_full}, 1);
        for (int i = 0; i < 9; i++) drive_pop();
        #1 chk("R11 empty", {31'd0, fifo_empty}, 1);
        chk("R11 scoreboard drained", exp_q.size(), 0);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule